// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block computes and commits the status changes that a core makes when it leaves a trap handler. The return can go back from supervisor level or from machine level. The CSR file supplies the current privilege level, the current guest-mode flag, the machine status word and the hypervisor status word. Two configuration inputs are also sampled: one says whether the hypervisor extension is present, the other selects between the newer and older interrupt-enable conventions. A one-cycle strobe requests a supervisor return or a machine return.

On the clock edge after a strobe, the unit publishes a complete new state in a single registered update. That state is made of the privilege level, the guest-mode flag, and both status words. With it come a one-cycle commit pulse and, when the return enters guest mode, a one-cycle request to swap the shadow register bank. A supervisor return made from user level raises an illegal-instruction pulse and leaves the published state untouched.

When the hypervisor extension is present and guest mode is off, a supervisor return unwinds a two-level stack of saved guest-mode and privilege bits. Level one returns to the caller, and level two drops into level one. In every other case the return follows the plain single-level rules.

Top module: `trap_return_unit`

## Requirements
- R1: During and after synchronous reset, with no strobe, the outputs are priv 2'b11 (machine), guest flag 0, both status words all zero, and the commit, illegal and swap pulses all 0. Privilege encoding: 2'b00 user, 2'b01 supervisor, 2'b11 machine.
- R2: A supervisor return with current privilege 2'b00 gives illegal_o=1 for exactly the next cycle, with done_o=0 and swap_o=0. Privilege, guest flag and both status words keep their previous values.
- R3: A supervisor return with the hypervisor extension present and guest mode off takes its new privilege from the old mstat bit 6, zero-extended. It takes its new guest flag from the old hstat bit 0. Both are the values before the update.
- R4: In the R3 case, hstat bit 0 receives the old hstat bit 1 and mstat bit 6 receives the old hstat bit 2. hstat bits 1 and 2 are then cleared.
- R5: In the R3 case, mstat bit 1 receives the old mstat bit 4, and mstat bit 4 becomes 1. This holds whatever the convention input says.
- R6: In the R3 case, swap_o pulses together with done_o exactly when the old hstat bit 0 was 1.
- R7: Any other legal supervisor return writes the old mstat bit 4 into an enable bit, clears mstat bit 4 and mstat bit 6, and leaves hstat and the guest flag (cur_virt_i) unchanged with no swap. The enable bit is mstat bit 1 under the newer convention (new_spec_i=1), or mstat bit (0 + old bit 6) under the older one.
- R8: A machine return takes its new privilege from old mstat[8:7] and writes the old mstat bit 5 into an enable bit. The enable bit is mstat bit 3 under the newer convention, or mstat bit (0 + old mstat[8:7]) under the older one. It then sets mstat bit 5 to 1 and clears mstat[8:7] and mstat bit 9.
- R9: On a machine return with the extension present, the new guest flag is the old mstat bit 9 and swap_o pulses if that bit was 1. Without the extension, the guest flag is cur_virt_i and there is no swap.
- R10: Every return commits all outputs in the single cycle after its strobe, with done_o=1 for that cycle. Back-to-back strobes commit on consecutive cycles.
- R11: If both strobes are high together, only the machine return is performed.
- R12: In a cycle with no strobe, the next cycle shows done_o, illegal_o and swap_o at 0 and all state outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sret_req_i | input | 1 | Supervisor-return strobe |
| mret_req_i | input | 1 | Machine-return strobe |
| cur_priv_i | input | 2 | Current privilege level |
| cur_virt_i | input | 1 | Current guest-mode flag |
| hyp_en_i | input | 1 | Hypervisor extension present |
| new_spec_i | input | 1 | 1 = newer enable-bit convention |
| mstat_i | input | 10 | Current machine status word |
| hstat_i | input | 3 | Current hypervisor status word |
| priv_o | output | 2 | Committed privilege level |
| virt_o | output | 1 | Committed guest-mode flag |
| mstat_o | output | 10 | Committed machine status word |
| hstat_o | output | 3 | Committed hypervisor status word |
| done_o | output | 1 | One-cycle commit pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| swap_o | output | 1 | One-cycle shadow-bank swap request |

## Verification
Several properties are checked on every cycle. An illegal pulse must leave all state stable, and it never coincides with a commit. A swap request only appears with a commit into guest mode. A machine return always leaves the saved-previous fields cleared and the prior-enable set. The two-level stack is always emptied after a hypervisor-aware supervisor return. Idle cycles hold state. The exact values that move between fields need the bench's scenarios to show them. These include the stack shift, the choice of enable bit under each convention, the guest flag with and without the extension, the priority between simultaneous strobes, and back-to-back commits.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int PW = 2;
  localparam int MW = 10;
  localparam int HW = 3;
  localparam int IW = $clog2(MW);

  localparam logic [PW-1:0] PRV_U = 2'b00;
  localparam logic [PW-1:0] PRV_S = 2'b01;
  localparam logic [PW-1:0] PRV_M = 2'b11;

  // machine status word layout; enable bits 0..3 are ordered by privilege
  localparam int F_UEN  = 0;
  localparam int F_SEN  = 1;
  localparam int F_MEN  = 3;
  localparam int F_SPEN = 4;
  localparam int F_MPEN = 5;
  localparam int F_SPP  = 6;
  localparam int F_MPPL = 7;
  localparam int F_MPPH = 8;
  localparam int F_MPV  = 9;

  // hypervisor status word layout: two-level return stack
  localparam int H_PV1 = 0;
  localparam int H_PV2 = 1;
  localparam int H_PP2 = 2;

  typedef struct packed {
    logic [PW-1:0] priv;
    logic          virt;
    logic [MW-1:0] ms;
    logic [HW-1:0] hs;
    logic          swap;
  } ret_res_t;
endpackage

// File: rtl/trp_sret_path.sv
module trp_sret_path
  import trp_pkg::*;
(
  input  logic [PW-1:0] priv_i,
  input  logic          virt_i,
  input  logic          hyp_en_i,
  input  logic          new_spec_i,
  input  logic [MW-1:0] ms_i,
  input  logic [HW-1:0] hs_i,
  output ret_res_t      res_o,
  output logic          illegal_o
);
  logic [IW-1:0] en_idx;

  always_comb begin
    illegal_o  = (priv_i < PRV_S);
    res_o.ms   = ms_i;
    res_o.hs   = hs_i;
    res_o.virt = virt_i;
    res_o.swap = 1'b0;
    res_o.priv = {1'b0, ms_i[F_SPP]};
    en_idx     = new_spec_i ? IW'(F_SEN) : (IW'(F_UEN) + IW'(ms_i[F_SPP]));
    if (hyp_en_i && !virt_i) begin
      // pop the two-level stack
      res_o.virt        = hs_i[H_PV1];
      res_o.swap        = hs_i[H_PV1];
      res_o.hs[H_PV1]   = hs_i[H_PV2];
      res_o.ms[F_SPP]   = hs_i[H_PP2];
      res_o.hs[H_PV2]   = 1'b0;
      res_o.hs[H_PP2]   = 1'b0;
      res_o.ms[F_SEN]   = ms_i[F_SPEN];
      res_o.ms[F_SPEN]  = 1'b1;
    end else begin
      res_o.ms[en_idx]  = ms_i[F_SPEN];
      res_o.ms[F_SPEN]  = 1'b0;
      res_o.ms[F_SPP]   = 1'b0;
    end
  end
endmodule

// File: rtl/trp_mret_path.sv
module trp_mret_path
  import trp_pkg::*;
(
  input  logic          virt_i,
  input  logic          hyp_en_i,
  input  logic          new_spec_i,
  input  logic [MW-1:0] ms_i,
  input  logic [HW-1:0] hs_i,
  output ret_res_t      res_o
);
  logic [IW-1:0] en_idx;

  always_comb begin
    res_o.ms   = ms_i;
    res_o.hs   = hs_i;
    res_o.priv = ms_i[F_MPPH:F_MPPL];
    res_o.virt = hyp_en_i ? ms_i[F_MPV] : virt_i;
    res_o.swap = hyp_en_i & ms_i[F_MPV];
    en_idx     = new_spec_i ? IW'(F_MEN) : (IW'(F_UEN) + IW'(ms_i[F_MPPH:F_MPPL]));
    res_o.ms[en_idx]        = ms_i[F_MPEN];
    res_o.ms[F_MPEN]        = 1'b1;
    res_o.ms[F_MPPH:F_MPPL] = 2'b00;
    res_o.ms[F_MPV]         = 1'b0;
  end
endmodule

// File: rtl/trp_commit.sv
module trp_commit
  import trp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sret_i,
  input  logic          mret_i,
  input  ret_res_t      sret_res_i,
  input  logic          sret_ill_i,
  input  ret_res_t      mret_res_i,
  output logic [PW-1:0] priv_o,
  output logic          virt_o,
  output logic [MW-1:0] ms_o,
  output logic [HW-1:0] hs_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          swap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      priv_o    <= PRV_M;
      virt_o    <= 1'b0;
      ms_o      <= '0;
      hs_o      <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      swap_o    <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      swap_o    <= 1'b0;
      if (mret_i) begin
        priv_o <= mret_res_i.priv;
        virt_o <= mret_res_i.virt;
        ms_o   <= mret_res_i.ms;
        hs_o   <= mret_res_i.hs;
        swap_o <= mret_res_i.swap;
        done_o <= 1'b1;
      end else if (sret_i) begin
        if (sret_ill_i) begin
          illegal_o <= 1'b1;
        end else begin
          priv_o <= sret_res_i.priv;
          virt_o <= sret_res_i.virt;
          ms_o   <= sret_res_i.ms;
          hs_o   <= sret_res_i.hs;
          swap_o <= sret_res_i.swap;
          done_o <= 1'b1;
        end
      end
    end
  end

  a_r2_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($stable(priv_o) && $stable(virt_o) && $stable(ms_o) && $stable(hs_o)));

  a_r10_done_excl_illegal: assert property (@(posedge clk) disable iff (rst)
    !(done_o && illegal_o));

  a_r6_swap_enters_guest: assert property (@(posedge clk) disable iff (rst)
    swap_o |-> (done_o && virt_o));

  a_r8_mret_clears: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mret_i)) |-> (ms_o[F_MPPH:F_MPPL] == 2'b00 && !ms_o[F_MPV] && ms_o[F_MPEN]));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(sret_i) && !$past(mret_i)) |->
      (!done_o && !swap_o && $stable(priv_o) && $stable(ms_o) && $stable(hs_o)));
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sret_req_i,
  input  logic          mret_req_i,
  input  logic [1:0]    cur_priv_i,
  input  logic          cur_virt_i,
  input  logic          hyp_en_i,
  input  logic          new_spec_i,
  input  logic [9:0]    mstat_i,
  input  logic [2:0]    hstat_i,
  output logic [1:0]    priv_o,
  output logic          virt_o,
  output logic [9:0]    mstat_o,
  output logic [2:0]    hstat_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          swap_o
);
  ret_res_t s_res;
  ret_res_t m_res;
  logic     s_ill;

  trp_sret_path u_sret (
    .priv_i     (cur_priv_i),
    .virt_i     (cur_virt_i),
    .hyp_en_i   (hyp_en_i),
    .new_spec_i (new_spec_i),
    .ms_i       (mstat_i),
    .hs_i       (hstat_i),
    .res_o      (s_res),
    .illegal_o  (s_ill)
  );

  trp_mret_path u_mret (
    .virt_i     (cur_virt_i),
    .hyp_en_i   (hyp_en_i),
    .new_spec_i (new_spec_i),
    .ms_i       (mstat_i),
    .hs_i       (hstat_i),
    .res_o      (m_res)
  );

  trp_commit u_commit (
    .clk        (clk),
    .rst        (rst),
    .sret_i     (sret_req_i),
    .mret_i     (mret_req_i),
    .sret_res_i (s_res),
    .sret_ill_i (s_ill),
    .mret_res_i (m_res),
    .priv_o     (priv_o),
    .virt_o     (virt_o),
    .ms_o       (mstat_o),
    .hs_o       (hstat_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .swap_o     (swap_o)
  );

  a_r4_hyp_stack_cleared: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(sret_req_i && !mret_req_i && hyp_en_i && !cur_virt_i)) |->
      (!hstat_o[H_PV2] && !hstat_o[H_PP2] && mstat_o[F_SPEN]));
endmodule

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic [9:0] ms;
    logic [2:0] hs;
    logic       done;
    logic       ill;
    logic       swap;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sret_req_i = 1'b0, mret_req_i = 1'b0;
  logic [1:0] cur_priv_i = 2'b11;
  logic       cur_virt_i = 1'b0, hyp_en_i = 1'b0, new_spec_i = 1'b1;
  logic [9:0] mstat_i = '0;
  logic [2:0] hstat_i = '0;
  logic [1:0] priv_o;
  logic       virt_o;
  logic [9:0] mstat_o;
  logic [2:0] hstat_o;
  logic       done_o, illegal_o, swap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  exp_t  expq[$];
  string tagq[$];
  exp_t  st;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_return_unit dut (
    .clk(clk), .rst(rst), .sret_req_i(sret_req_i), .mret_req_i(mret_req_i),
    .cur_priv_i(cur_priv_i), .cur_virt_i(cur_virt_i), .hyp_en_i(hyp_en_i),
    .new_spec_i(new_spec_i), .mstat_i(mstat_i), .hstat_i(hstat_i),
    .priv_o(priv_o), .virt_o(virt_o), .mstat_o(mstat_o), .hstat_o(hstat_o),
    .done_o(done_o), .illegal_o(illegal_o), .swap_o(swap_o)
  );

  function automatic exp_t actual();
    exp_t a;
    a.priv = priv_o; a.virt = virt_o; a.ms = mstat_o; a.hs = hstat_o;
    a.done = done_o; a.ill = illegal_o; a.swap = swap_o;
    return a;
  endfunction

  // driver: computes the expected result from the requirements and queues it
  task automatic step(input string tag, input logic s, input logic m,
                      input logic [1:0] p, input logic v, input logic h,
                      input logic ns, input logic [9:0] ms, input logic [2:0] hs);
    logic [9:0] nm;
    logic [2:0] nh;
    int idx;
    @(negedge clk);
    sret_req_i = s; mret_req_i = m; cur_priv_i = p; cur_virt_i = v;
    hyp_en_i = h; new_spec_i = ns; mstat_i = ms; hstat_i = hs;
    st.done = 1'b0; st.ill = 1'b0; st.swap = 1'b0;
    nm = ms; nh = hs;
    if (m) begin
      idx = ns ? 3 : int'(ms[8:7]);
      nm[idx] = ms[5]; nm[5] = 1'b1; nm[8:7] = 2'b00; nm[9] = 1'b0;
      st.priv = ms[8:7]; st.virt = h ? ms[9] : v; st.swap = h & ms[9];
      st.ms = nm; st.hs = nh; st.done = 1'b1;
    end else if (s) begin
      if (p == 2'b00) begin
        st.ill = 1'b1;
      end else if (h && !v) begin
        st.priv = {1'b0, ms[6]}; st.virt = hs[0]; st.swap = hs[0];
        nh[0] = hs[1]; nh[1] = 1'b0; nh[2] = 1'b0;
        nm[6] = hs[2]; nm[1] = ms[4]; nm[4] = 1'b1;
        st.ms = nm; st.hs = nh; st.done = 1'b1;
      end else begin
        idx = ns ? 1 : int'(ms[6]);
        nm[idx] = ms[4]; nm[4] = 1'b0; nm[6] = 1'b0;
        st.priv = {1'b0, ms[6]}; st.virt = v;
        st.ms = nm; st.hs = nh; st.done = 1'b1;
      end
    end
    expq.push_back(st);
    tagq.push_back(tag);
  endtask

  // monitor: compares one queued item per cycle after the registers update
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        exp_t a;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        a = actual();
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual priv=%b virt=%b ms=%b hs=%b done=%b ill=%b swap=%b, expected priv=%b virt=%b ms=%b hs=%b done=%b ill=%b swap=%b",
                   t, a.priv, a.virt, a.ms, a.hs, a.done, a.ill, a.swap,
                   e.priv, e.virt, e.ms, e.hs, e.done, e.ill, e.swap);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running, expected finished");
    finish_run();
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, checked while reset is held
    r = '{priv:2'b11, virt:1'b0, ms:10'h000, hs:3'b000, done:1'b0, ill:1'b0, swap:1'b0};
    n_chk++;
    if (actual() !== r) begin
      n_bad++;
      $display("FAIL R1: actual %b expected %b", actual(), r);
    end
    @(negedge clk);
    rst = 1'b0;
    st = r;
    step("R1 R12", 0, 0, 2'b11, 1'b0, 1'b1, 1'b1, 10'h3FF, 3'h7);
    step("R3 R4 R5 R6", 1, 0, 2'b11, 1'b0, 1'b1, 1'b1, 10'h050, 3'b101);
    step("R4 R6", 1, 0, 2'b01, 1'b0, 1'b1, 1'b1, 10'h000, 3'b010);
    step("R5 old-convention", 1, 0, 2'b01, 1'b0, 1'b1, 1'b0, 10'h011, 3'b100);
    step("R2", 1, 0, 2'b00, 1'b0, 1'b1, 1'b1, 10'h3FF, 3'h7);
    step("R12", 0, 0, 2'b00, 1'b1, 1'b0, 1'b0, 10'h155, 3'h2);
    step("R7 new", 1, 0, 2'b01, 1'b0, 1'b0, 1'b1, 10'h050, 3'h5);
    step("R7 old spp0", 1, 0, 2'b01, 1'b0, 1'b0, 1'b0, 10'h010, 3'h0);
    step("R7 old spp1", 1, 0, 2'b11, 1'b0, 1'b0, 1'b0, 10'h050, 3'h0);
    step("R7 guest on", 1, 0, 2'b01, 1'b1, 1'b1, 1'b1, 10'h052, 3'h5);
    step("R8 R9 hyp", 0, 1, 2'b11, 1'b0, 1'b1, 1'b1, 10'h2A0, 3'h0);
    step("R9 no hyp", 0, 1, 2'b11, 1'b1, 1'b0, 1'b1, 10'h2A0, 3'h3);
    step("R8 old mpp0", 0, 1, 2'b11, 1'b1, 1'b1, 1'b0, 10'h020, 3'h0);
    step("R8 old mpp3", 0, 1, 2'b11, 1'b0, 1'b0, 1'b0, 10'h1A0, 3'h0);
    step("R11", 1, 1, 2'b00, 1'b0, 1'b1, 1'b1, 10'h2A0, 3'h5);
    step("R10 first", 1, 0, 2'b11, 1'b0, 1'b1, 1'b1, 10'h050, 3'h5);
    step("R10 second", 0, 1, 2'b01, 1'b1, 1'b1, 1'b1, 10'h1B0, 3'h0);
    step("R2 legacy", 1, 0, 2'b00, 1'b1, 1'b0, 1'b0, 10'h3FF, 3'h7);
    step("R12 after illegal", 0, 0, 2'b11, 1'b0, 1'b0, 1'b1, 10'h000, 3'h0);
    step("R12", 0, 0, 2'b11, 1'b0, 1'b0, 1'b1, 10'h000, 3'h0);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule